// File: doc/BRIEF.md
# Atomic Compare-Swap and Masked-Swap Unit

This unit performs one atomic read-modify-write on a 32-bit word memory port per command. A command brings a pair of data operands (a primary value and a secondary value that is either a compare key or a bit mask), a base address and a 10-bit signed offset. The unit reads the word at the effective address, computes the word to store, writes it back to the same address and returns the word it read.

There are two operations. Compare-and-swap stores the primary value only when the word read equals the key; otherwise it stores the word read, unchanged. Masked swap keeps the memory bits where the mask is 0 and takes the primary value's bits where the mask is 1. Three addressing modes choose the effective address and the updated base: short offset, post-increment and pre-increment.

A lock output stays high from the read request until the write is acknowledged, so no other master can reach memory between the two accesses. A one-cycle done pulse presents the old word and the updated base.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset the unit is idle: busy, done, mem_req and mem_lock are all 0.
- R2: Each command makes exactly one read request (mem_we=0) followed by exactly one write request (mem_we=1) to the same address. mem_lock is 1 on both requests and stays 1 until the write is acknowledged. It is 0 in the cycle done is 1.
- R3: With op=0 (compare-and-swap), when the word read equals data_odd, the word written is data_even.
- R4: With op=0, when the word read differs from data_odd, the word written is the word read, unchanged.
- R5: With op=1 (masked swap), the word written is (data_even AND data_odd) OR (word read AND NOT data_odd).
- R6: For both operations, old_word equals the word read while done is 1.
- R7: With amode=00 (short offset) or amode=11, the access address is base_in plus the sign-extended offset. base_out equals base_in.
- R8: With amode=01 (post-increment), the access address is base_in. base_out is base_in plus the sign-extended offset.
- R9: With amode=10 (pre-increment), the access address and base_out both equal base_in plus the sign-extended offset.
- R10: A start pulse while busy is 1 is ignored. It causes no extra memory access and no extra done pulse.
- R11: done is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command; sampled only when idle |
| op | input | 1 | 0 = compare-and-swap, 1 = masked swap |
| amode | input | 2 | 00 short offset, 01 post-increment, 10 pre-increment, 11 short offset |
| data_even | input | 32 | Primary value to store or merge |
| data_odd | input | 32 | Compare key (op=0) or bit mask (op=1) |
| base_in | input | 32 | Base address |
| offset | input | 10 | Signed byte offset |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| old_word | output | 32 | Word read from memory, valid with done |
| base_out | output | 32 | Updated base, valid with done |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data; byte at the lowest address in bits 7:0 |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_lock | output | 1 | Bus lock for the read-modify-write |

## Verification
Compare-and-swap runs once with a key that equals the stored word and once with a key that does not, which separates the store-new path from the store-back path. A second matching swap on a word the unit has just written confirms that the new value reached memory. Masked swap runs with a half-word mask, an all-zero mask and an alternating mask, which shows that every bit is taken from the correct source. Offsets at +511, -512, small negatives and small positives cover each addressing mode, and a start pulse sent mid-command must leave both memory and the done count unchanged.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int OW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op,
  input  logic [1:0]    amode,
  input  logic [DW-1:0] data_even,
  input  logic [DW-1:0] data_odd,
  input  logic [AW-1:0] base_in,
  input  logic [OW-1:0] offset,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] old_word,
  output logic [AW-1:0] base_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          mem_lock
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWT, S_WR, S_WWT, S_DONE} st_t;

  st_t           st;
  logic          op_q;
  logic [DW-1:0] val_q, key_q, old_q, wd_q;
  logic [AW-1:0] ea_q, nb_q;

  wire [AW-1:0] off_ext = {{(AW-OW){offset[OW-1]}}, offset};
  wire [AW-1:0] sum     = base_in + off_ext;
  wire          post    = (amode == 2'b01);
  wire          pre     = (amode == 2'b10);

  wire [DW-1:0] cas_val = (mem_rdata == key_q) ? val_q : mem_rdata;
  wire [DW-1:0] msk_val = (val_q & key_q) | (mem_rdata & ~key_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= 1'b0;
      val_q <= '0;
      key_q <= '0;
      old_q <= '0;
      wd_q  <= '0;
      ea_q  <= '0;
      nb_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q  <= op;
          val_q <= data_even;
          key_q <= data_odd;
          ea_q  <= post ? base_in : sum;
          nb_q  <= (post || pre) ? sum : base_in;
          st    <= S_RD;
        end
        S_RD:  st <= S_RWT;
        S_RWT: if (mem_ack) begin
          old_q <= mem_rdata;
          wd_q  <= op_q ? msk_val : cas_val;
          st    <= S_WR;
        end
        S_WR:   st <= S_WWT;
        S_WWT:  if (mem_ack) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign old_word  = old_q;
  assign base_out  = nb_q;
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = ea_q;
  assign mem_wdata = wd_q;
  assign mem_lock  = (st == S_RD) || (st == S_RWT) || (st == S_WR) || (st == S_WWT);

  AST_REQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock); // R2
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lock) |-> (mem_req && !mem_we)); // R2
  AST_UNLOCK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_lock); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !mem_lock)); // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && $past(mem_lock)) |-> $stable(mem_addr)); // R2

endmodule

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op = 1'b0;
  logic [1:0]  amode = 2'b00;
  logic [31:0] data_even = '0, data_odd = '0, base_in = '0;
  logic [9:0]  offset = '0;
  logic        busy, done, mem_req, mem_we, mem_lock;
  logic [31:0] old_word, base_out, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_rmw_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .amode(amode),
    .data_even(data_even), .data_odd(data_odd), .base_in(base_in), .offset(offset),
    .busy(busy), .done(done), .old_word(old_word), .base_out(base_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_lock(mem_lock)
  );

  int total = 0, bad = 0;
  int lat = 1;
  int done_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] mem [logic [31:0]];

  typedef struct {
    logic [31:0] addr, wdata, old, nbase;
    string tag;
  } exp_t;
  exp_t q [$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with configurable latency
  logic        pend = 1'b0, pwe = 1'b0;
  logic [31:0] paddr = '0, pwd = '0;
  int          cnt = 0;
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_ack <= 1'b1;
        if (pwe) mem[paddr] = pwd;
        else mem_rdata <= mem.exists(paddr) ? mem[paddr] : 32'h0;
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_req) begin
      pend <= 1'b1; cnt <= lat; paddr <= mem_addr; pwe <= mem_we; pwd <= mem_wdata;
    end
  end

  // monitor
  logic [31:0] seen_rd, seen_wr, seen_wd;
  logic        prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        chk(mem_lock, "R2 lock on request", {31'b0, mem_lock}, 32'h1);
        if (mem_we) begin seen_wr = mem_addr; seen_wd = mem_wdata; wr_cnt++; end
        else begin seen_rd = mem_addr; rd_cnt++; end
      end
      if (prev_done)
        chk(!done, "R11 done one cycle", {31'b0, done}, 32'h0);
      if (done) begin
        exp_t e;
        done_cnt++;
        chk(!mem_lock, "R2 lock low at done", {31'b0, mem_lock}, 32'h0);
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 32'h1, 32'h0);
        end else begin
          e = q.pop_front();
          chk(seen_rd == e.addr, {e.tag, " read address"}, seen_rd, e.addr);
          chk(seen_wr == e.addr, "R2 write address same as read", seen_wr, e.addr);
          chk(seen_wd == e.wdata, {e.tag, " write data"}, seen_wd, e.wdata);
          chk(old_word == e.old, "R6 old word", old_word, e.old);
          chk(base_out == e.nbase, {e.tag, " base_out"}, base_out, e.nbase);
        end
      end
      prev_done = done;
    end
  end

  task automatic run_op(bit o, logic [1:0] m, logic [31:0] ev, logic [31:0] od,
                        logic [31:0] b, logic [9:0] off, string tag, bit poke);
    exp_t e;
    logic [31:0] sx, s, ld;
    int want;
    sx = {{22{off[9]}}, off};
    s  = b + sx;
    e.addr  = (m == 2'b01) ? b : s;
    e.nbase = (m == 2'b01 || m == 2'b10) ? s : b;
    ld = mem.exists(e.addr) ? mem[e.addr] : 32'h0;
    e.old = ld;
    if (o) e.wdata = (ev & od) | (ld & ~od);
    else   e.wdata = (ld == od) ? ev : ld;
    e.tag = tag;
    q.push_back(e);
    want = done_cnt + 1;
    @(negedge clk);
    op = o; amode = m; data_even = ev; data_odd = od; base_in = b; offset = off;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: second start while busy must be ignored
      op = 1'b1; amode = 2'b00; data_even = 32'hFFFFFFFF; data_odd = 32'hFFFFFFFF;
      base_in = 32'h0000_9000; offset = 10'h0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_cnt == want);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_up();
  end

  initial begin
    mem[32'h0000_1008] = 32'hAAAA5555;
    mem[32'h0000_2000] = 32'h11112222;
    mem[32'h0000_31FF] = 32'hF0F0F0F0;
    mem[32'h0000_3E00] = 32'hCAFEF00D;
    mem[32'h0000_5010] = 32'h00FF00FF;
    mem[32'h0000_9000] = 32'h5A5A5A5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", {31'b0, busy}, 32'h0);
    chk(!done, "R1 done", {31'b0, done}, 32'h0);
    chk(!mem_req, "R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk(!mem_lock, "R1 mem_lock", {31'b0, mem_lock}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    lat = 1;
    run_op(1'b0, 2'b00, 32'h12345678, 32'hAAAA5555, 32'h1000, 10'd8,   "R3 R7 cas match short", 1'b0);
    lat = 3;
    run_op(1'b0, 2'b01, 32'hDEADBEEF, 32'h00000000, 32'h2000, 10'h3FC, "R4 R8 cas miss post", 1'b0);
    lat = 0;
    run_op(1'b1, 2'b10, 32'h0F0F1234, 32'hFFFF0000, 32'h3000, 10'h1FF, "R5 R9 mask pre", 1'b0);
    lat = 2;
    run_op(1'b1, 2'b00, 32'h77777777, 32'h00000000, 32'h4000, 10'h200, "R5 R7 zero mask short", 1'b0);
    run_op(1'b0, 2'b11, 32'h00000000, 32'h12345678, 32'h1010, 10'h3F8, "R3 R7 cas match mode3", 1'b0);
    lat = 4;
    run_op(1'b1, 2'b01, 32'hAAAAAAAA, 32'h0F0F0F0F, 32'h5010, 10'h0,   "R5 R8 alt mask post", 1'b1);
    run_op(1'b0, 2'b10, 32'hBBBB0000, 32'h99999999, 32'h2004, 10'h3FC, "R4 R9 cas miss pre", 1'b0);

    chk(mem[32'h0000_9000] == 32'h5A5A5A5A, "R10 memory untouched", mem[32'h0000_9000], 32'h5A5A5A5A);
    chk(done_cnt == 7, "R10 done count", done_cnt, 32'd7);
    chk(rd_cnt == 7 && wr_cnt == 7, "R2 R10 access count", rd_cnt + wr_cnt, 32'd14);
    chk(q.size() == 0, "R6 scoreboard drained", q.size(), 32'd0);
    finish_up();
  end
endmodule